// File: doc/BRIEF.md
# Escaped Byte Stream Packet Encoder

This block turns a stream of packet payload bytes into the raw byte stream carried on a serial link. Each packet is wrapped in a start marker and a channel header. An end marker is placed in the stream just before the final payload byte. Any payload byte that matches a framing or link-level control value is replaced by a two-byte escape sequence, so control values never appear as data. Whenever there is nothing to send, including gaps in the middle of a packet, the encoder fills the slot with the link idle value.

Payload arrives on a valid/ready interface with first and last flags. On the output side, a serializer raises a request each time it needs the next byte, and the encoder must always supply one. The output byte is combinational from the encoder state and the payload input while the request is high. The encoder takes that byte, and advances its state, at the clock edge where the request is high. The channel number is fixed at zero.

Top module: `esc_pkt_encoder`

## Requirements
- R1: After reset, with no payload offered, the output byte is 0x4A.
- R2: A packet begins with the three bytes 0x7A, 0x7C, 0x00, in that order, before any payload-derived byte.
- R3: A payload byte of value 0x7A, 0x7B, 0x7C or 0x7D is emitted as 0x7D followed by that value XOR 0x20.
- R4: A payload byte of value 0x4A or 0x4D is emitted as 0x4D followed by that value XOR 0x20. All other payload bytes are emitted unchanged.
- R5: The end marker 0x7B is emitted immediately before the last payload byte. If that byte needs escaping, the marker comes before its escape prefix. The last byte is not accepted until the marker has been emitted.
- R6: While a packet is open and no payload byte is valid, and between packets, the output byte is 0x4A.
- R7: No payload byte is accepted while the second byte of an escape sequence is still pending. A payload byte is accepted only in a cycle where the output request is high.
- R8: With the output request low, the encoder state does not advance and ready is low. The emitted stream is the same regardless of how requests are spaced.
- R9: A one-byte packet is emitted as 0x7A, 0x7C, 0x00, 0x7B, then the byte, escaped if needed.
- R10: A valid payload byte without the first flag, offered while no packet is open, is accepted and discarded. The output stays 0x4A and the following packet is unaffected.
- R11: An N-byte payload in which every byte needs escaping encodes to exactly 2N+4 bytes, which is the longest possible encoding.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inData | input | 8 | Payload byte |
| inValid | input | 1 | Payload byte valid |
| inFirst | input | 1 | Payload byte is the first of its packet |
| inLast | input | 1 | Payload byte is the last of its packet |
| inReady | output | 1 | Payload byte taken at this clock edge |
| outReq | input | 1 | Serializer takes outByte at this clock edge |
| outByte | output | 8 | Link byte presented to the serializer |

## Verification
The embedded assertions check on every cycle the following rules:
- ready never rises without a request, and never rises while an escape tail is pending;
- the last byte is only taken once the end marker is out;
- a byte routed straight through is never a control value;
- a held escape tail is always one of the six transformed control values;
- the state freezes while there is no request.

Only the directed scenarios can show whole-stream properties:
- the exact header order;
- where the end marker sits relative to an escape prefix;
- the 2N+4 length bound;
- idle insertion inside a packet;
- that irregular request spacing leaves the stream unchanged;
- that an orphan byte leaves no trace.

// File: rtl/esc_enc_pkg.sv
package esc_enc_pkg;

  localparam int BYTE_W = 8;

  localparam logic [7:0] CODE_START   = 8'h7A;
  localparam logic [7:0] CODE_END     = 8'h7B;
  localparam logic [7:0] CODE_CHAN    = 8'h7C;
  localparam logic [7:0] CODE_PKT_ESC = 8'h7D;
  localparam logic [7:0] CODE_IDLE    = 8'h4A;
  localparam logic [7:0] CODE_PHY_ESC = 8'h4D;
  localparam logic [7:0] ESC_FLIP     = 8'h20;
  localparam logic [7:0] CHAN_NUM     = 8'h00;

  localparam int PKT_CODE_N = 4;
  localparam int PHY_CODE_N = 2;

  typedef enum logic [2:0] {
    SEL_IDLE,
    SEL_START,
    SEL_CHAN,
    SEL_CHNUM,
    SEL_END,
    SEL_PREFIX,
    SEL_DATA,
    SEL_HOLD
  } outSel_e;

  typedef struct packed {
    outSel_e sel;
    logic    loadHold;
  } encStrobe_t;

endpackage

// File: rtl/esc_enc_classify.sv
module esc_enc_classify
  import esc_enc_pkg::*;
#(
  parameter int W = BYTE_W
) (
  input  logic [W-1:0] byteIn,
  output logic         isPktCode,
  output logic         isPhyCode
);

  localparam logic [7:0] PKT_SET [PKT_CODE_N] = '{CODE_START, CODE_END, CODE_CHAN, CODE_PKT_ESC};
  localparam logic [7:0] PHY_SET [PHY_CODE_N] = '{CODE_IDLE, CODE_PHY_ESC};

  logic [PKT_CODE_N-1:0] pktHit;
  logic [PHY_CODE_N-1:0] phyHit;

  for (genvar g = 0; g < PKT_CODE_N; g++) begin : g_pkt
    assign pktHit[g] = (byteIn == PKT_SET[g]);
  end

  for (genvar g = 0; g < PHY_CODE_N; g++) begin : g_phy
    assign phyHit[g] = (byteIn == PHY_SET[g]);
  end

  assign isPktCode = |pktHit;
  assign isPhyCode = |phyHit;

endmodule

// File: rtl/esc_enc_datapath.sv
module esc_enc_datapath
  import esc_enc_pkg::*;
#(
  parameter int W = BYTE_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] inData,
  input  logic         inLast,
  input  encStrobe_t   strobe,
  output logic         isSpecial,
  output logic         holdLast,
  output logic [W-1:0] outByte
);

  logic         isPktCode;
  logic         isPhyCode;
  logic [W-1:0] holdByte;
  logic [W-1:0] flipped;
  logic [W-1:0] prefix;

  esc_enc_classify #(.W(W)) u_class (
    .byteIn    (inData),
    .isPktCode (isPktCode),
    .isPhyCode (isPhyCode)
  );

  assign isSpecial = isPktCode | isPhyCode;
  assign flipped   = inData ^ ESC_FLIP;
  assign prefix    = isPktCode ? CODE_PKT_ESC : CODE_PHY_ESC;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      holdByte <= CODE_IDLE;
      holdLast <= 1'b0;
    end else if (strobe.loadHold) begin
      holdByte <= flipped;
      holdLast <= inLast;
    end
  end

  always_comb begin
    unique case (strobe.sel)
      SEL_START:  outByte = CODE_START;
      SEL_CHAN:   outByte = CODE_CHAN;
      SEL_CHNUM:  outByte = CHAN_NUM;
      SEL_END:    outByte = CODE_END;
      SEL_PREFIX: outByte = prefix;
      SEL_DATA:   outByte = inData;
      SEL_HOLD:   outByte = holdByte;
      default:    outByte = CODE_IDLE;
    endcase
  end

  // R3 R4: a byte routed straight through is never a control value
  assert_data_not_special_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.sel == SEL_DATA) |-> !(isPktCode || isPhyCode));

  // R4: a pending escape tail is one of the six transformed control values
  assert_hold_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.sel == SEL_HOLD) |->
      (holdByte == 8'h5A || holdByte == 8'h5B || holdByte == 8'h5C ||
       holdByte == 8'h5D || holdByte == 8'h6A || holdByte == 8'h6D));

endmodule

// File: rtl/esc_enc_ctrl.sv
module esc_enc_ctrl
  import esc_enc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       inValid,
  input  logic       inFirst,
  input  logic       inLast,
  input  logic       outReq,
  input  logic       isSpecial,
  input  logic       holdLast,
  output logic       inReady,
  output encStrobe_t strobe
);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHAN,
    ST_CHNUM,
    ST_BODY,
    ST_TAIL
  } encState_e;

  encState_e state, stateNext;
  logic      endSent, endSentNext;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      endSent <= 1'b0;
    end else begin
      state   <= stateNext;
      endSent <= endSentNext;
    end
  end

  always_comb begin
    stateNext       = state;
    endSentNext     = endSent;
    inReady         = 1'b0;
    strobe.sel      = SEL_IDLE;
    strobe.loadHold = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (inValid && inFirst) begin
          strobe.sel  = SEL_START;
          endSentNext = 1'b0;
          if (outReq) stateNext = ST_CHAN;
        end else begin
          inReady = outReq;
        end
      end
      ST_CHAN: begin
        strobe.sel = SEL_CHAN;
        if (outReq) stateNext = ST_CHNUM;
      end
      ST_CHNUM: begin
        strobe.sel = SEL_CHNUM;
        if (outReq) stateNext = ST_BODY;
      end
      ST_BODY: begin
        if (!inValid) begin
          strobe.sel = SEL_IDLE;
        end else if (inLast && !endSent) begin
          strobe.sel = SEL_END;
          if (outReq) endSentNext = 1'b1;
        end else if (isSpecial) begin
          strobe.sel      = SEL_PREFIX;
          inReady         = outReq;
          strobe.loadHold = outReq;
          if (outReq) stateNext = ST_TAIL;
        end else begin
          strobe.sel = SEL_DATA;
          inReady    = outReq;
          if (outReq && inLast) begin
            stateNext   = ST_IDLE;
            endSentNext = 1'b0;
          end
        end
      end
      ST_TAIL: begin
        strobe.sel = SEL_HOLD;
        if (outReq) begin
          stateNext = holdLast ? ST_IDLE : ST_BODY;
          if (holdLast) endSentNext = 1'b0;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  assert_ready_needs_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
    inReady |-> outReq);

  assert_tail_blocks_input_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_TAIL) |-> !inReady);

  assert_last_after_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_BODY && inValid && inReady && inLast) |-> endSent);

  assert_freeze_without_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !outReq |=> ($stable(state) && $stable(endSent)));

endmodule

// File: rtl/esc_pkt_encoder.sv
module esc_pkt_encoder
  import esc_enc_pkg::*;
#(
  parameter int W = BYTE_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] inData,
  input  logic         inValid,
  input  logic         inFirst,
  input  logic         inLast,
  output logic         inReady,
  input  logic         outReq,
  output logic [W-1:0] outByte
);

  encStrobe_t strobe;
  logic       isSpecial;
  logic       holdLast;

  esc_enc_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .inValid   (inValid),
    .inFirst   (inFirst),
    .inLast    (inLast),
    .outReq    (outReq),
    .isSpecial (isSpecial),
    .holdLast  (holdLast),
    .inReady   (inReady),
    .strobe    (strobe)
  );

  esc_enc_datapath #(.W(W)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .inData    (inData),
    .inLast    (inLast),
    .strobe    (strobe),
    .isSpecial (isSpecial),
    .holdLast  (holdLast),
    .outByte   (outByte)
  );

endmodule

// File: tb/esc_pkt_encoder_tb.sv
module esc_pkt_encoder_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] inData = 8'h00;
  logic       inValid = 1'b0;
  logic       inFirst = 1'b0;
  logic       inLast = 1'b0;
  logic       inReady;
  logic       outReq = 1'b1;
  logic [7:0] outByte;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  logic [7:0] pl  [0:31];
  int         plN;
  logic [7:0] expS [0:79];
  int         expN;
  logic [7:0] got [0:79];
  int         gotN;
  int         idleIn;

  esc_pkt_encoder u_dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .inData  (inData),
    .inValid (inValid),
    .inFirst (inFirst),
    .inLast  (inLast),
    .inReady (inReady),
    .outReq  (outReq),
    .outByte (outByte)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles == 150000) begin
      errors++;
      $display("FAIL watchdog: act %0d cycles exp fewer", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: act 0x%0h exp 0x%0h", req, act, exp);
    end
  endtask

  function automatic bit isCtl(input logic [7:0] b);
    return (b == 8'h7A || b == 8'h7B || b == 8'h7C || b == 8'h7D || b == 8'h4A || b == 8'h4D);
  endfunction

  task automatic buildExpected();
    expN = 0;
    expS[expN++] = 8'h7A;
    expS[expN++] = 8'h7C;
    expS[expN++] = 8'h00;
    for (int i = 0; i < plN; i++) begin
      if (i == plN - 1) expS[expN++] = 8'h7B;
      if (isCtl(pl[i])) begin
        expS[expN++] = (pl[i] == 8'h4A || pl[i] == 8'h4D) ? 8'h4D : 8'h7D;
        expS[expN++] = pl[i] ^ 8'h20;
      end else begin
        expS[expN++] = pl[i];
      end
    end
  endtask

  task automatic runStream(input int gapAt, input bit stall);
    int  idx = 0;
    int  cyc = 0;
    int  extra = 0;
    bit  gapped = 1'b0;
    bit  gapNow;
    gotN = 0;
    idleIn = 0;
    while (extra < 8 && cyc < 2000) begin
      @(negedge clk);
      outReq = stall ? ((cyc % 3) != 1) : 1'b1;
      gapNow = (idx == gapAt) && !gapped && outReq && (idx < plN);
      if (gapNow) gapped = 1'b1;
      inValid = (idx < plN) && !gapNow;
      inData  = (idx < plN) ? pl[idx] : 8'h00;
      inFirst = (idx == 0);
      inLast  = (idx == plN - 1);
      #2;
      if (outReq) begin
        if (outByte == 8'h4A) begin
          if (idx > 0 && idx < plN) idleIn++;
        end else if (gotN < 80) begin
          got[gotN++] = outByte;
        end
      end
      if (inValid && inReady) idx++;
      if (idx >= plN) extra++;
      cyc++;
    end
    @(negedge clk);
    inValid = 1'b0;
    inFirst = 1'b0;
    inLast  = 1'b0;
    outReq  = 1'b1;
  endtask

  task automatic compareStream(input string req);
    int bad = -1;
    check(gotN == expN, {req, " length"}, gotN, expN);
    for (int i = 0; i < expN && i < gotN; i++)
      if (bad < 0 && got[i] !== expS[i]) bad = i;
    if (bad >= 0) check(1'b0, {req, " byte"}, got[bad], expS[bad]);
    else check(1'b1, req, 0, 0);
  endtask

  task automatic drive(input bit req, input bit v, input bit f, input bit l, input logic [7:0] d);
    @(negedge clk);
    outReq = req; inValid = v; inFirst = f; inLast = l; inData = d;
    #2;
  endtask

  task automatic testReset();
    @(negedge clk);
    #2;
    check(outByte == 8'h4A, "R1 idle after reset", outByte, 8'h4A);
  endtask

  task automatic testPlain();
    plN = 4; pl[0] = 8'h11; pl[1] = 8'h22; pl[2] = 8'h33; pl[3] = 8'h44;
    buildExpected();
    runStream(-1, 1'b0);
    compareStream("R2 R5 plain packet");
    check(got[0] == 8'h7A && got[1] == 8'h7C && got[2] == 8'h00, "R2 header", got[1], 8'h7C);
  endtask

  task automatic testPktEscape();
    plN = 5; pl[0] = 8'h7A; pl[1] = 8'h7B; pl[2] = 8'h7C; pl[3] = 8'h7D; pl[4] = 8'h55;
    buildExpected();
    runStream(-1, 1'b0);
    compareStream("R3 packet-layer escapes");
  endtask

  task automatic testPhyEscape();
    plN = 3; pl[0] = 8'h4A; pl[1] = 8'h4D; pl[2] = 8'h10;
    buildExpected();
    runStream(-1, 1'b0);
    compareStream("R4 link-layer escapes");
  endtask

  task automatic testLastEscaped();
    plN = 2; pl[0] = 8'h12; pl[1] = 8'h7D;
    buildExpected();
    runStream(-1, 1'b0);
    compareStream("R5 end marker before prefix");
    check(gotN == 7 && got[4] == 8'h7B && got[5] == 8'h7D, "R5 order", got[4], 8'h7B);
  endtask

  task automatic testSingle();
    plN = 1; pl[0] = 8'h33;
    buildExpected();
    runStream(-1, 1'b0);
    compareStream("R9 single plain byte");
    plN = 1; pl[0] = 8'h4A;
    buildExpected();
    runStream(-1, 1'b0);
    compareStream("R9 single escaped byte");
  endtask

  task automatic testWorstLength();
    plN = 8;
    for (int i = 0; i < 8; i++) pl[i] = (i % 3 == 0) ? 8'h4D : 8'h7A + 8'(i % 4);
    buildExpected();
    runStream(-1, 1'b0);
    compareStream("R11 all-escaped packet");
    check(gotN == 2 * plN + 4, "R11 length bound", gotN, 2 * plN + 4);
  endtask

  task automatic testGap();
    plN = 4; pl[0] = 8'h01; pl[1] = 8'h02; pl[2] = 8'h03; pl[3] = 8'h04;
    buildExpected();
    runStream(2, 1'b0);
    compareStream("R6 packet with gap");
    check(idleIn == 1, "R6 idle inside packet", idleIn, 1);
  endtask

  task automatic testStall();
    plN = 6; pl[0] = 8'h7B; pl[1] = 8'h21; pl[2] = 8'h4A; pl[3] = 8'h99; pl[4] = 8'h7C; pl[5] = 8'h4D;
    buildExpected();
    runStream(-1, 1'b1);
    compareStream("R8 spaced requests");
  endtask

  task automatic testHold();
    drive(1, 1, 1, 0, 8'h7D);
    check(outByte == 8'h7A && !inReady, "R2 start, no accept", outByte, 8'h7A);
    drive(1, 1, 1, 0, 8'h7D);
    check(outByte == 8'h7C && !inReady, "R2 channel flag", outByte, 8'h7C);
    drive(1, 1, 1, 0, 8'h7D);
    check(outByte == 8'h00 && !inReady, "R2 channel number", outByte, 8'h00);
    drive(1, 1, 1, 0, 8'h7D);
    check(outByte == 8'h7D && inReady, "R3 prefix with accept", outByte, 8'h7D);
    drive(0, 1, 0, 1, 8'h22);
    check(!inReady, "R8 no accept without request", inReady, 0);
    check(outByte == 8'h5D, "R8 tail held during stall", outByte, 8'h5D);
    drive(1, 1, 0, 1, 8'h22);
    check(outByte == 8'h5D && !inReady, "R7 tail blocks input", inReady, 0);
    drive(1, 1, 0, 1, 8'h22);
    check(outByte == 8'h7B && !inReady, "R5 end marker first", outByte, 8'h7B);
    drive(1, 1, 0, 1, 8'h22);
    check(outByte == 8'h22 && inReady, "R5 last byte taken", outByte, 8'h22);
    drive(1, 0, 0, 0, 8'h00);
    check(outByte == 8'h4A, "R6 idle between packets", outByte, 8'h4A);
  endtask

  task automatic testOrphan();
    drive(1, 1, 0, 0, 8'h55);
    check(outByte == 8'h4A && inReady, "R10 orphan accepted as idle", outByte, 8'h4A);
    drive(1, 0, 0, 0, 8'h00);
    check(outByte == 8'h4A, "R10 still idle", outByte, 8'h4A);
    plN = 2; pl[0] = 8'h66; pl[1] = 8'h77;
    buildExpected();
    runStream(-1, 1'b0);
    compareStream("R10 next packet clean");
  endtask

  initial begin
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    testReset();
    testPlain();
    testPktEscape();
    testPhyEscape();
    testLastEscaped();
    testSingle();
    testWorstLength();
    testGap();
    testStall();
    testHold();
    testOrphan();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule